// File: doc/BRIEF.md
# Data Value Compare Debug Unit

This block watches the data side of memory accesses (loads, stores and cache-management operations) and raises debug events when the bytes being moved equal a value programmed by the debugger. It carries two independent compare channels. Each channel has a 32-bit compare word, a 4-bit lane-select mask and a 2-bit combining mode. Each access presents a starting byte address, a size, a read/write flag and the data placed on the four byte lanes of the aligned word. Alongside these comes a per-channel qualifier from the address-compare logic, which lives outside this block.

A channel only looks at the lanes that are really moved inside the aligned word that holds the first byte. Bytes that spill into the following word take no part. The per-lane results are merged in one of three ways: all selected lanes, any selected lane, or either half of the word in full. A hit sets a sticky read-hit or write-hit flag for the channel. An address-only event from outside sets the same flags. Software clears a flag with a one-cycle clear pulse.

Top module: `dvc_watch`

## Requirements
- R1: While rst_n is low, and at the first sample after it rises, every read-hit and write-hit flag is 0.
- R2: Byte lane i (i = 0..3) is acc_data[31-8i -: 8], so lane 0 is the most significant byte. It is compared with the same bit range of the channel's compare word. Bit i of the channel's lane-select mask selects lane i.
- R3: acc_size encodes the byte count minus one (0 = 1 byte, 1 = 2, 2 = 3, 3 = 4). The lanes taken as moved run from acc_addr[1:0] up to acc_addr[1:0] + acc_size, capped at lane 3. Bytes past lane 3 are ignored.
- R4: Mode 1 (all) hits when the mask is non-zero and every selected lane is both moved and equal.
- R5: Mode 2 (any) hits when at least one selected lane is both moved and equal.
- R6: Mode 3 (halves) hits when lanes {0,1} satisfy the all-rule over their selected lanes, or lanes {2,3} do. A half with no selected lane never satisfies its side.
- R7: Mode 0, or a lane-select mask of 0000, never produces a data-compare hit.
- R8: A data-compare hit needs acc_valid and that channel's addr_qual bit high in the same cycle.
- R9: A hit, or an addr_evt pulse during a valid access, sets the channel's write flag when acc_write is 1 and its read flag otherwise, one clock later. Channels do not affect each other.
- R10: A flag stays set until a clr_rd/clr_wr pulse on its bit. When a clear and a new hit on the same flag arrive in the same cycle, the flag stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Access strobe |
| acc_write | input | 1 | 1 = store, 0 = load or cache operation |
| acc_addr | input | 2 | Starting byte offset within the aligned word |
| acc_size | input | 2 | Byte count minus one |
| acc_data | input | 32 | Data on the four byte lanes |
| addr_qual | input | NCH | Per-channel address-compare qualifier |
| addr_evt | input | NCH | Per-channel address-only event |
| cmp_val | input | NCH*32 | Compare words, channel c at [32c +: 32] |
| lane_sel | input | NCH*4 | Lane-select masks, channel c at [4c +: 4] |
| cmp_mode | input | NCH*2 | Combining modes, channel c at [2c +: 2] |
| clr_rd | input | NCH | Clear pulses for read-hit flags |
| clr_wr | input | NCH | Clear pulses for write-hit flags |
| hit_rd | output | NCH | Sticky read-hit flags |
| hit_wr | output | NCH | Sticky write-hit flags |

## Verification
The only state is the sticky flag pair of each channel. A wrong lane mask, mode decode or byte slice shows up on hit_rd or hit_wr one clock after the access that should, or should not, have hit. It stays visible there until a clear. A lost or spurious clear likewise shows on the next sample after the pulse. So every access pattern is judged by a single check one cycle later, with the flags cleared between patterns so that no earlier result hides a later one.

// File: rtl/dvc_pkg.sv
package dvc_pkg;
    localparam int LANES  = 4;
    localparam int BYTE_W = 8;
    localparam int WORD_W = LANES * BYTE_W;

    typedef enum logic [1:0] {
        MODE_OFF  = 2'd0,
        MODE_ALL  = 2'd1,
        MODE_ANY  = 2'd2,
        MODE_HALF = 2'd3
    } cmp_mode_e;

    typedef struct packed {
        logic [1:0] rd;
        logic [1:0] wr;
    } flag_pair_t;
endpackage

// File: rtl/dvc_lane_sel.sv
module dvc_lane_sel
    import dvc_pkg::*;
(
    input  logic [1:0]       offset,
    input  logic [1:0]       size_m1,
    output logic [LANES-1:0] moved
);
    logic [2:0] first_lane;
    logic [2:0] last_lane;

    always_comb begin
        first_lane = {1'b0, offset};
        last_lane  = {1'b0, offset} + {1'b0, size_m1};
    end

    // Lanes past index 3 simply do not exist here, so the spill is dropped.
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        localparam logic [2:0] IDX = 3'(i);
        assign moved[i] = (IDX >= first_lane) && (IDX <= last_lane);
    end
endmodule

// File: rtl/dvc_chan_cmp.sv
module dvc_chan_cmp
    import dvc_pkg::*;
(
    input  logic [LANES-1:0]  moved,
    input  logic [WORD_W-1:0] data,
    input  logic [WORD_W-1:0] ref_word,
    input  logic [LANES-1:0]  sel,
    input  logic [1:0]        mode,
    output logic              match
);
    logic [LANES-1:0] lane_ok;
    logic [LANES-1:0] lane_pass;
    logic             all_ok;
    logic             any_ok;
    logic             lo_ok;
    logic             hi_ok;

    for (genvar i = 0; i < LANES; i++) begin : g_cmp
        localparam int HI = WORD_W - 1 - BYTE_W * i;
        assign lane_ok[i] = moved[i] && (data[HI -: BYTE_W] == ref_word[HI -: BYTE_W]);
    end

    always_comb begin
        lane_pass = ~sel | lane_ok;
        all_ok    = (|sel) && (&lane_pass);
        any_ok    = |(sel & lane_ok);
        lo_ok     = (|sel[1:0]) && (&lane_pass[1:0]);
        hi_ok     = (|sel[3:2]) && (&lane_pass[3:2]);
        unique case (cmp_mode_e'(mode))
            MODE_ALL:  match = all_ok;
            MODE_ANY:  match = any_ok;
            MODE_HALF: match = lo_ok || hi_ok;
            default:   match = 1'b0;
        endcase
    end
endmodule

// File: rtl/dvc_watch.sv
module dvc_watch
    import dvc_pkg::*;
#(
    parameter int NCH = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                acc_valid,
    input  logic                acc_write,
    input  logic [1:0]          acc_addr,
    input  logic [1:0]          acc_size,
    input  logic [WORD_W-1:0]   acc_data,
    input  logic [NCH-1:0]      addr_qual,
    input  logic [NCH-1:0]      addr_evt,
    input  logic [NCH*WORD_W-1:0] cmp_val,
    input  logic [NCH*LANES-1:0]  lane_sel,
    input  logic [NCH*2-1:0]    cmp_mode,
    input  logic [NCH-1:0]      clr_rd,
    input  logic [NCH-1:0]      clr_wr,
    output logic [NCH-1:0]      hit_rd,
    output logic [NCH-1:0]      hit_wr
);
    typedef struct packed {
        logic [NCH-1:0] rd;
        logic [NCH-1:0] wr;
    } flags_t;

    flags_t           flags_d;
    flags_t           flags_q;
    logic [LANES-1:0] moved;
    logic [NCH-1:0]   data_hit;
    logic [NCH-1:0]   chan_evt;

    dvc_lane_sel u_lanes (
        .offset  (acc_addr),
        .size_m1 (acc_size),
        .moved   (moved)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        dvc_chan_cmp u_cmp (
            .moved    (moved),
            .data     (acc_data),
            .ref_word (cmp_val[c*WORD_W +: WORD_W]),
            .sel      (lane_sel[c*LANES +: LANES]),
            .mode     (cmp_mode[c*2 +: 2]),
            .match    (data_hit[c])
        );
    end

    always_comb begin
        chan_evt   = {NCH{acc_valid}} & ((data_hit & addr_qual) | addr_evt);
        flags_d    = flags_q;
        flags_d.rd = (flags_q.rd & ~clr_rd) | (chan_evt & {NCH{~acc_write}});
        flags_d.wr = (flags_q.wr & ~clr_wr) | (chan_evt & {NCH{acc_write}});
    end

    always_ff @(posedge clk) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= flags_d;
    end

    assign hit_rd = flags_q.rd;
    assign hit_wr = flags_q.wr;
endmodule

// File: rtl/dvc_watch_chk.sv
module dvc_watch_chk
    import dvc_pkg::*;
#(
    parameter int NCH = 2
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 acc_valid,
    input logic                 acc_write,
    input logic [NCH-1:0]       addr_qual,
    input logic [NCH-1:0]       addr_evt,
    input logic [NCH*LANES-1:0] lane_sel,
    input logic [NCH*2-1:0]     cmp_mode,
    input logic [NCH-1:0]       clr_rd,
    input logic [NCH-1:0]       clr_wr,
    input logic [NCH-1:0]       hit_rd,
    input logic [NCH-1:0]       hit_wr
);
    for (genvar c = 0; c < NCH; c++) begin : g_chk
        // R9: a read flag only rises after a valid read access
        p_rd_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(hit_rd[c]) |-> $past(acc_valid && !acc_write));
        // R9: a write flag only rises after a valid write access
        p_wr_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(hit_wr[c]) |-> $past(acc_valid && acc_write));
        // R10: flags only fall after a clear pulse
        p_rd_fall_r10: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(hit_rd[c]) |-> $past(clr_rd[c]));
        p_wr_fall_r10: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(hit_wr[c]) |-> $past(clr_wr[c]));
        // R10: with no access and no clear the flags hold
        p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
            (!acc_valid && !clr_rd[c] && !clr_wr[c]) |=> $stable({hit_rd[c], hit_wr[c]}));
        // R7: mode 0 or empty mask with no address event cannot set a clear read flag
        p_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (acc_valid && !acc_write && !addr_evt[c] && !hit_rd[c] &&
             (cmp_mode[c*2 +: 2] == 2'd0 || lane_sel[c*LANES +: LANES] == '0))
            |=> !hit_rd[c]);
        // R8: without the qualifier or an address event a clear read flag stays clear
        p_qual_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (acc_valid && !acc_write && !addr_qual[c] && !addr_evt[c] && !hit_rd[c])
            |=> !hit_rd[c]);
    end
endmodule

bind dvc_watch dvc_watch_chk #(.NCH(NCH)) u_dvc_watch_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_valid (acc_valid),
    .acc_write (acc_write),
    .addr_qual (addr_qual),
    .addr_evt  (addr_evt),
    .lane_sel  (lane_sel),
    .cmp_mode  (cmp_mode),
    .clr_rd    (clr_rd),
    .clr_wr    (clr_wr),
    .hit_rd    (hit_rd),
    .hit_wr    (hit_wr)
);

// File: tb/dvc_watch_bench.sv
module dvc_watch_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NCH        = 2;
    localparam int NVEC       = 16;
    localparam int WATCHDOG   = 20000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          acc_valid = 1'b0;
    logic          acc_write = 1'b0;
    logic [1:0]    acc_addr = '0;
    logic [1:0]    acc_size = '0;
    logic [31:0]   acc_data = '0;
    logic [1:0]    addr_qual = '0;
    logic [1:0]    addr_evt = '0;
    logic [63:0]   cmp_val = '0;
    logic [7:0]    lane_sel = '0;
    logic [3:0]    cmp_mode = '0;
    logic [1:0]    clr_rd = '0;
    logic [1:0]    clr_wr = '0;
    logic [1:0]    hit_rd;
    logic [1:0]    hit_wr;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dvc_watch #(.NCH(NCH)) u_dvc_watch (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
        .acc_addr(acc_addr), .acc_size(acc_size), .acc_data(acc_data),
        .addr_qual(addr_qual), .addr_evt(addr_evt), .cmp_val(cmp_val),
        .lane_sel(lane_sel), .cmp_mode(cmp_mode), .clr_rd(clr_rd),
        .clr_wr(clr_wr), .hit_rd(hit_rd), .hit_wr(hit_wr)
    );

    // {sel[3:0], mode[1:0], addr[1:0], size[1:0], qual, expect, data[31:0]}
    // Channel 0 compare word is A1B2C3D4 (lane0 = A1 ... lane3 = D4).
    localparam logic [43:0] VEC [NVEC] = '{
        {4'hF, 2'd1, 2'd0, 2'd3, 1'b1, 1'b1, 32'hA1B2C3D4}, // R4 full word all
        {4'hF, 2'd1, 2'd0, 2'd3, 1'b1, 1'b0, 32'hA1B2C3FF}, // R4 lane3 differs
        {4'hF, 2'd1, 2'd1, 2'd3, 1'b1, 1'b0, 32'h00B2C3D4}, // R3 lane0 not moved
        {4'hE, 2'd1, 2'd1, 2'd3, 1'b1, 1'b1, 32'h00B2C3D4}, // R3 spill ignored
        {4'hF, 2'd2, 2'd3, 2'd0, 1'b1, 1'b1, 32'h000000D4}, // R5 single lane3
        {4'h1, 2'd2, 2'd3, 2'd0, 1'b1, 1'b0, 32'hA1B2C3D4}, // R2 lane0 only selected, not moved
        {4'hF, 2'd2, 2'd0, 2'd1, 1'b1, 1'b1, 32'h00B20000}, // R5 lane1 match
        {4'hF, 2'd3, 2'd0, 2'd1, 1'b1, 1'b1, 32'hA1B20000}, // R6 low half
        {4'hF, 2'd3, 2'd2, 2'd1, 1'b1, 1'b1, 32'h0000C3D4}, // R6 high half
        {4'hF, 2'd3, 2'd1, 2'd1, 1'b1, 1'b0, 32'h00B2C300}, // R6 straddle
        {4'hC, 2'd3, 2'd0, 2'd1, 1'b1, 1'b0, 32'hA1B20000}, // R6 empty low half
        {4'h3, 2'd3, 2'd0, 2'd1, 1'b1, 1'b1, 32'hA1B20000}, // R6 low half selected
        {4'hF, 2'd0, 2'd0, 2'd3, 1'b1, 1'b0, 32'hA1B2C3D4}, // R7 mode 0
        {4'h0, 2'd1, 2'd0, 2'd3, 1'b1, 1'b0, 32'hA1B2C3D4}, // R7 empty mask
        {4'hF, 2'd1, 2'd0, 2'd3, 1'b0, 1'b0, 32'hA1B2C3D4}, // R8 no qualifier
        {4'h4, 2'd1, 2'd2, 2'd0, 1'b1, 1'b1, 32'h0000C300}  // R2 lane2 alone
    };

    task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: {wr,rd} actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic access(input logic wr, input logic [1:0] addr, input logic [1:0] sz,
                          input logic [31:0] data);
        @(negedge clk);
        acc_valid = 1'b1; acc_write = wr; acc_addr = addr; acc_size = sz; acc_data = data;
        @(negedge clk);
        acc_valid = 1'b0;
    endtask

    task automatic clear_all();
        @(negedge clk);
        clr_rd = 2'b11; clr_wr = 2'b11;
        @(negedge clk);
        clr_rd = 2'b00; clr_wr = 2'b00;
    endtask

    initial begin
        cmp_val[31:0]  = 32'hA1B2C3D4;
        cmp_val[63:32] = 32'h11223344;
        repeat (3) @(negedge clk);
        check("R1", {hit_wr, hit_rd}, 4'b0000);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", {hit_wr, hit_rd}, 4'b0000);

        for (int v = 0; v < NVEC; v++) begin
            lane_sel[3:0] = VEC[v][43:40];
            cmp_mode[1:0] = VEC[v][39:38];
            addr_qual[0]  = VEC[v][33];
            access(1'b0, VEC[v][37:36], VEC[v][35:34], VEC[v][31:0]);
            check($sformatf("R2-R8 vector %0d", v), {hit_wr, hit_rd}, {3'b000, VEC[v][32]});
            clear_all();
        end

        // R9: write on channel 1 sets only its write flag
        lane_sel  = {4'hF, 4'h0};
        cmp_mode  = {2'd2, 2'd0};
        addr_qual = 2'b11;
        access(1'b1, 2'd0, 2'd0, 32'h11000000);
        check("R9 write ch1", {hit_wr, hit_rd}, 4'b1000);
        // R10: flag holds over idle cycles
        repeat (3) @(negedge clk);
        check("R10 sticky", {hit_wr, hit_rd}, 4'b1000);
        // R10: clearing the other flags leaves it set
        clr_rd = 2'b11; clr_wr = 2'b01;
        @(negedge clk);
        clr_rd = 2'b00; clr_wr = 2'b00;
        @(negedge clk);
        check("R10 other clear", {hit_wr, hit_rd}, 4'b1000);
        // R10: clear and hit in the same cycle keeps the flag
        clr_wr = 2'b10;
        access(1'b1, 2'd1, 2'd0, 32'h00220000);
        clr_wr = 2'b00;
        check("R10 hit wins", {hit_wr, hit_rd}, 4'b1000);
        // R10: clear alone drops it
        clr_wr = 2'b10;
        @(negedge clk);
        clr_wr = 2'b00;
        check("R10 clear", {hit_wr, hit_rd}, 4'b0000);
        // R9: read on channel 1 sets its read flag
        access(1'b0, 2'd0, 2'd3, 32'h00000044);
        check("R9 read ch1", {hit_wr, hit_rd}, 4'b0010);
        clear_all();
        // R9: address event on channel 0 sets its flag though its compare is off
        addr_evt = 2'b01;
        access(1'b0, 2'd0, 2'd0, 32'h0);
        addr_evt = 2'b00;
        check("R9 address event", {hit_wr, hit_rd}, 4'b0001);
        clear_all();
        // R9: address event without a valid access does nothing
        addr_evt = 2'b11;
        @(negedge clk);
        @(negedge clk);
        addr_evt = 2'b00;
        check("R9 event idle", {hit_wr, hit_rd}, 4'b0000);
        // R9: both channels hit on one write
        lane_sel = {4'hF, 4'hF};
        cmp_mode = {2'd2, 2'd2};
        access(1'b1, 2'd0, 2'd3, 32'hA1223300);
        check("R9 both channels", {hit_wr, hit_rd}, 4'b1100);
        // R1: reset mid-run clears everything
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check("R1 re-reset", {hit_wr, hit_rd}, 4'b0000);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule